// File: doc/BRIEF.md
# Retirement-Gated Cache Set Controller

This block manages the tags and replacement order of one set of a private cache that serves a core which issues loads speculatively. A small side buffer, the staging buffer, sits next to the set. When a fill comes back for a miss, the block it carries is held in the staging buffer instead of going into the set. The block moves into the set only when a load that referenced it retires. Recency order in the set changes only at retirement. A load on a mispredicted path can therefore read from the set or the buffer, but it never changes which blocks are resident or in what order they age.

The core sends every speculative lookup with an instruction id, and the block records the looked-up tag against that id. An in-order retire port names the id that is leaving the pipeline, and the block then acts on the recorded tag. A flush port removes every younger record and every younger staged block. The set's tags, valid bits and ages are brought out as observation ports, so a replayed sequence can be compared across runs.

Top module: `retire_gated_set`

## Requirements
- R1: After reset all ways are invalid, the age of way i is i (age 0 is most recent, age 3 is least recent), the staging buffer is empty, fill_ready is 1 and rsp_valid is 0.
- R2: One cycle after acc_valid, rsp_valid is 1. rsp_hit is 1 exactly when acc_tag matches a valid way or a valid staging entry, using the state that was present when the access was presented. An access changes no tag, valid bit or age.
- R3: An accepted fill is parked in the staging buffer and leaves set_tags, set_valid and set_ages unchanged. A later access to its tag reports a hit.
- R4: fill_ready is 0 while all 4 staging entries are valid. A fill presented while fill_ready is 0 is not stored.
- R5: When an id retires whose recorded tag is in the staging buffer, the tag is written into the way of age 3 in the same cycle. That way becomes valid with age 0, every other way's age goes up by 1, and the staging entry is freed.
- R6: When an id retires whose recorded tag is in a valid way, that way takes age 0. Ways whose age was lower than its old age go up by 1, and all other ways keep their age.
- R7: Retiring an id that has no record, or whose recorded tag is neither in the set nor in the staging buffer, changes nothing.
- R8: A flush with id F removes every staging entry and every access record whose id x satisfies ((x - F) mod 32) < 16. All older entries and records are kept.
- R9: A fill whose tag is already in a valid way or a valid staging entry is dropped and takes no staging entry.
- R10: The same retired sequence yields the same final tags, valid bits and ages whether or not wrong-path accesses and fills, later flushed, are mixed into it.
- R11: A block moved into the set replaces only the way that held age 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Speculative lookup request |
| acc_tag | input | TAG_W | Tag looked up |
| acc_id | input | ID_W | Instruction id of the lookup |
| rsp_valid | output | 1 | Lookup response valid, one cycle later |
| rsp_hit | output | 1 | Lookup hit in the set or the staging buffer |
| fill_valid | input | 1 | Fill data returned for a miss |
| fill_tag | input | TAG_W | Tag of the returned block |
| fill_id | input | ID_W | Id of the instruction that missed |
| fill_ready | output | 1 | Staging buffer can take a fill |
| ret_valid | input | 1 | An instruction retires |
| ret_id | input | ID_W | Id of the retiring instruction, in program order |
| flush_valid | input | 1 | Pipeline flush |
| flush_id | input | ID_W | Oldest id discarded by the flush |
| set_tags | output | WAYS*TAG_W | Tag of way i at bits [i*TAG_W +: TAG_W] |
| set_valid | output | WAYS | Valid bit per way |
| set_ages | output | WAYS*2 | Age of way i at bits [2*i +: 2] |

## Verification
The central case replays one retired sequence twice, once clean and once with wrong-path lookups of resident tags and wrong-path fills that are later flushed. A controller that updated recency on lookup, or admitted fills early, would end with a different age vector or a different evicted way. Directed cases fill the staging buffer until fill_ready drops, offer a fill while stalled, and flush at a middle id so that some entries survive and some do not. They also send duplicate fills, which a design that did not drop them would count against buffer capacity. A fixed vector table follows a sequence of promotions, a touch of an old block and an eviction, and checks that the way of age 3 is the one that gets replaced.

// File: rtl/rgs_pkg.sv
package rgs_pkg;

  typedef enum logic [1:0] {
    RET_IDLE    = 2'd0,
    RET_TOUCH   = 2'd1,
    RET_PROMOTE = 2'd2
  } ret_act_e;

  // True when id is the same as or younger than ref_id within a wrapping
  // id space of the given width (half-window ordering).
  function automatic logic seq_at_or_after(input logic [31:0] id,
                                           input logic [31:0] ref_id,
                                           input int unsigned width);
    logic [31:0] mask;
    logic [31:0] diff;
    mask = (32'd1 << width) - 32'd1;
    diff = (id - ref_id) & mask;
    return diff < (32'd1 << (width - 1));
  endfunction

endpackage

// File: rtl/rgs_age_ctrl.sv
module rgs_age_ctrl #(
  parameter int WAYS  = 4,
  parameter int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  touch_en,
  input  logic [AGE_W-1:0]      touch_way,
  output logic [WAYS*AGE_W-1:0] ages_o,
  output logic [AGE_W-1:0]      lru_way_o
);

  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [AGE_W-1:0] age_q [WAYS];
  logic [AGE_W-1:0] hit_age;

  function automatic logic [AGE_W-1:0] age_after_touch(
      input logic [AGE_W-1:0] cur,
      input logic [AGE_W-1:0] ref_age,
      input logic             is_tgt);
    if (is_tgt)           return '0;
    else if (cur < ref_age) return cur + AGE_W'(1);
    else                  return cur;
  endfunction

  assign hit_age = age_q[touch_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) age_q[w] <= AGE_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++)
        age_q[w] <= age_after_touch(age_q[w], hit_age, touch_way == AGE_W'(w));
    end
  end

  always_comb begin
    lru_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (age_q[w] == OLDEST) lru_way_o = AGE_W'(w);
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_flat
    assign ages_o[w*AGE_W +: AGE_W] = age_q[w];
  end

  // Checker state and properties
  logic [AGE_W-1:0] chk_way_q;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_way_q <= '0;
    else        chk_way_q <= touch_way;
  end

  for (genvar k = 0; k < WAYS; k++) begin : g_perm
    logic [WAYS-1:0] holds_k;
    for (genvar w = 0; w < WAYS; w++) begin : g_m
      assign holds_k[w] = (age_q[w] == AGE_W'(k));
    end
    // R6
    perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(holds_k));
  end

  // R2
  age_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_en |=> $stable(ages_o));

  // R6
  touch_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (age_q[chk_way_q] == '0));

endmodule

// File: rtl/rgs_vbuf.sv
module rgs_vbuf
  import rgs_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 12,
  parameter int ID_W    = 5,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic [ID_W-1:0]  alloc_id,
  input  logic [TAG_W-1:0] lk_a_tag,
  output logic             lk_a_hit,
  input  logic [TAG_W-1:0] lk_r_tag,
  output logic             lk_r_hit,
  output logic [IDX_W-1:0] lk_r_idx,
  input  logic [TAG_W-1:0] lk_f_tag,
  output logic             lk_f_hit,
  input  logic             free_en,
  input  logic [IDX_W-1:0] free_idx,
  input  logic             flush_en,
  input  logic [ID_W-1:0]  flush_id,
  output logic             full_o
);

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [ID_W-1:0]    owner_q [ENTRIES];
  logic [IDX_W-1:0]   slot;
  logic               has_slot;
  logic               alloc_ok;

  always_comb begin
    lk_a_hit = 1'b0;
    lk_r_hit = 1'b0;
    lk_r_idx = '0;
    lk_f_hit = 1'b0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (vld_q[e] && tag_q[e] == lk_a_tag) lk_a_hit = 1'b1;
      if (vld_q[e] && tag_q[e] == lk_f_tag) lk_f_hit = 1'b1;
      if (vld_q[e] && tag_q[e] == lk_r_tag) begin
        lk_r_hit = 1'b1;
        lk_r_idx = IDX_W'(e);
      end
    end
  end

  always_comb begin
    slot     = '0;
    has_slot = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!vld_q[e]) begin
        slot     = IDX_W'(e);
        has_slot = 1'b1;
      end
    end
  end

  assign full_o   = !has_slot;
  assign alloc_ok = alloc_en && has_slot &&
                    !(flush_en && seq_at_or_after(32'(alloc_id), 32'(flush_id), ID_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tag_q[e]   <= '0;
        owner_q[e] <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (flush_en && seq_at_or_after(32'(owner_q[e]), 32'(flush_id), ID_W))
          vld_q[e] <= 1'b0;
        if (free_en && free_idx == IDX_W'(e))
          vld_q[e] <= 1'b0;
        if (alloc_ok && slot == IDX_W'(e)) begin
          vld_q[e]   <= 1'b1;
          tag_q[e]   <= alloc_tag;
          owner_q[e] <= alloc_id;
        end
      end
    end
  end

  // Checker state and properties
  logic [ID_W-1:0] chk_flush_id_q;
  logic            stale_after_flush;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_flush_id_q <= '0;
    else        chk_flush_id_q <= flush_id;
  end
  always_comb begin
    stale_after_flush = 1'b0;
    for (int e = 0; e < ENTRIES; e++)
      if (vld_q[e] && seq_at_or_after(32'(owner_q[e]), 32'(chk_flush_id_q), ID_W))
        stale_after_flush = 1'b1;
  end

  // R4
  vb_noovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full_o);

  // R8
  vb_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> !stale_after_flush);

  // R5
  vb_free_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |-> vld_q[free_idx]);

endmodule

// File: rtl/rgs_pend.sv
module rgs_pend
  import rgs_pkg::*;
#(
  parameter int ID_W  = 5,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [ID_W-1:0]  rd_id,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             clr_en,
  input  logic [ID_W-1:0]  clr_id,
  input  logic             flush_en,
  input  logic [ID_W-1:0]  flush_id
);

  localparam int NUM = 1 << ID_W;

  logic [NUM-1:0]   vld_q;
  logic [TAG_W-1:0] tag_q [NUM];

  assign rd_valid = vld_q[rd_id];
  assign rd_tag   = tag_q[rd_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < NUM; i++) tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM; i++) begin
        if (flush_en && seq_at_or_after(32'(i), 32'(flush_id), ID_W))
          vld_q[i] <= 1'b0;
        if (clr_en && clr_id == ID_W'(i))
          vld_q[i] <= 1'b0;
        if (wr_en && wr_id == ID_W'(i)) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= wr_tag;
        end
      end
    end
  end

endmodule

// File: rtl/retire_gated_set.sv
module retire_gated_set
  import rgs_pkg::*;
#(
  parameter int WAYS       = 4,
  parameter int VB_ENTRIES = 4,
  parameter int TAG_W      = 12,
  parameter int ID_W       = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_valid,
  input  logic [TAG_W-1:0]      acc_tag,
  input  logic [ID_W-1:0]       acc_id,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  input  logic                  fill_valid,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic [ID_W-1:0]       fill_id,
  output logic                  fill_ready,
  input  logic                  ret_valid,
  input  logic [ID_W-1:0]       ret_id,
  input  logic                  flush_valid,
  input  logic [ID_W-1:0]       flush_id,
  output logic [WAYS*TAG_W-1:0] set_tags,
  output logic [WAYS-1:0]       set_valid,
  output logic [WAYS*2-1:0]     set_ages
);

  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int VIDX_W = (VB_ENTRIES > 1) ? $clog2(VB_ENTRIES) : 1;

  logic [TAG_W-1:0] tag_q [WAYS];
  logic [WAYS-1:0]  vld_q;
  logic             rsp_valid_q, rsp_hit_q;

  // Lookup results
  logic             set_hit_a, set_hit_f, set_hit_r;
  logic [AGE_W-1:0] set_way_r;
  logic             vb_hit_a, vb_hit_f, vb_hit_r;
  logic [VIDX_W-1:0] vb_idx_r;
  logic             vb_full;

  // Retire path
  logic             rec_valid;
  logic [TAG_W-1:0] rec_tag;
  ret_act_e         ret_act;
  logic             touch_ev, promote_ev, evict_ev;
  logic [AGE_W-1:0] touch_way;
  logic [AGE_W-1:0] lru_way;
  logic [WAYS*AGE_W-1:0] ages_flat;

  // Fill and access events
  logic fill_fire, alloc_ev, rec_wr_ev;

  always_comb begin
    set_hit_a = 1'b0;
    set_hit_f = 1'b0;
    set_hit_r = 1'b0;
    set_way_r = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[w] && tag_q[w] == acc_tag)  set_hit_a = 1'b1;
      if (vld_q[w] && tag_q[w] == fill_tag) set_hit_f = 1'b1;
      if (vld_q[w] && tag_q[w] == rec_tag) begin
        set_hit_r = 1'b1;
        set_way_r = AGE_W'(w);
      end
    end
  end

  rgs_pend #(.ID_W(ID_W), .TAG_W(TAG_W)) pend_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (rec_wr_ev),
    .wr_id    (acc_id),
    .wr_tag   (acc_tag),
    .rd_id    (ret_id),
    .rd_valid (rec_valid),
    .rd_tag   (rec_tag),
    .clr_en   (ret_valid),
    .clr_id   (ret_id),
    .flush_en (flush_valid),
    .flush_id (flush_id)
  );

  rgs_vbuf #(.ENTRIES(VB_ENTRIES), .TAG_W(TAG_W), .ID_W(ID_W)) vbuf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_ev),
    .alloc_tag (fill_tag),
    .alloc_id  (fill_id),
    .lk_a_tag  (acc_tag),
    .lk_a_hit  (vb_hit_a),
    .lk_r_tag  (rec_tag),
    .lk_r_hit  (vb_hit_r),
    .lk_r_idx  (vb_idx_r),
    .lk_f_tag  (fill_tag),
    .lk_f_hit  (vb_hit_f),
    .free_en   (promote_ev),
    .free_idx  (vb_idx_r),
    .flush_en  (flush_valid),
    .flush_id  (flush_id),
    .full_o    (vb_full)
  );

  rgs_age_ctrl #(.WAYS(WAYS), .AGE_W(AGE_W)) age_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_ev),
    .touch_way (touch_way),
    .ages_o    (ages_flat),
    .lru_way_o (lru_way)
  );

  // Retire decision: a resident tag is touched, a staged tag is promoted.
  always_comb begin
    ret_act = RET_IDLE;
    if (ret_valid && rec_valid) begin
      if (set_hit_r)     ret_act = RET_TOUCH;
      else if (vb_hit_r) ret_act = RET_PROMOTE;
    end
  end

  assign promote_ev = (ret_act == RET_PROMOTE);
  assign touch_ev   = (ret_act != RET_IDLE);
  assign touch_way  = promote_ev ? lru_way : set_way_r;
  assign evict_ev   = promote_ev && vld_q[lru_way];

  assign fill_ready = !vb_full;
  assign fill_fire  = fill_valid && fill_ready;
  assign alloc_ev   = fill_fire && !set_hit_f && !vb_hit_f;
  assign rec_wr_ev  = acc_valid &&
                      !(flush_valid && seq_at_or_after(32'(acc_id), 32'(flush_id), ID_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int w = 0; w < WAYS; w++) tag_q[w] <= '0;
    end else if (promote_ev) begin
      tag_q[lru_way] <= rec_tag;
      vld_q[lru_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= acc_valid;
      rsp_hit_q   <= acc_valid && (set_hit_a || vb_hit_a);
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign set_valid = vld_q;
  assign set_ages  = ages_flat;

  for (genvar w = 0; w < WAYS; w++) begin : g_tags
    assign set_tags[w*TAG_W +: TAG_W] = tag_q[w];
  end

  // R3
  set_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !promote_ev |=> ($stable(set_tags) && $stable(set_valid)));

  // R11
  evict_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    promote_ev |-> (ages_flat[lru_way*AGE_W +: AGE_W] == AGE_W'(WAYS - 1)));

  // R5
  promote_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_ev |=> $countones(set_valid) == $countones($past(set_valid)));

endmodule

// File: tb/retire_gated_set_tb.sv
module retire_gated_set_tb_top;

  localparam int WAYS  = 4;
  localparam int TAG_W = 12;
  localparam int ID_W  = 5;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  acc_valid = 1'b0;
  logic [TAG_W-1:0]      acc_tag = '0;
  logic [ID_W-1:0]       acc_id = '0;
  logic                  rsp_valid, rsp_hit;
  logic                  fill_valid = 1'b0;
  logic [TAG_W-1:0]      fill_tag = '0;
  logic [ID_W-1:0]       fill_id = '0;
  logic                  fill_ready;
  logic                  ret_valid = 1'b0;
  logic [ID_W-1:0]       ret_id = '0;
  logic                  flush_valid = 1'b0;
  logic [ID_W-1:0]       flush_id = '0;
  logic [WAYS*TAG_W-1:0] set_tags;
  logic [WAYS-1:0]       set_valid;
  logic [WAYS*2-1:0]     set_ages;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  retire_gated_set dut_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_tag(acc_tag), .acc_id(acc_id),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_id(fill_id),
    .fill_ready(fill_ready),
    .ret_valid(ret_valid), .ret_id(ret_id),
    .flush_valid(flush_valid), .flush_id(flush_id),
    .set_tags(set_tags), .set_valid(set_valid), .set_ages(set_ages)
  );

  // Vector: [23:22] op (0 lookup, 1 fill, 2 retire), [21] expected hit,
  // [20:16] id, [11:0] tag
  localparam int NV = 21;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 1'b0, 5'd1, 16'h010}, {2'd1, 1'b0, 5'd1, 16'h010},
    {2'd0, 1'b1, 5'd2, 16'h010}, {2'd2, 1'b0, 5'd1, 16'h000},
    {2'd0, 1'b1, 5'd3, 16'h010}, {2'd2, 1'b0, 5'd2, 16'h000},
    {2'd0, 1'b0, 5'd4, 16'h020}, {2'd1, 1'b0, 5'd4, 16'h020},
    {2'd2, 1'b0, 5'd4, 16'h000},
    {2'd0, 1'b0, 5'd5, 16'h030}, {2'd1, 1'b0, 5'd5, 16'h030},
    {2'd2, 1'b0, 5'd5, 16'h000},
    {2'd0, 1'b0, 5'd6, 16'h040}, {2'd1, 1'b0, 5'd6, 16'h040},
    {2'd2, 1'b0, 5'd6, 16'h000},
    {2'd0, 1'b1, 5'd7, 16'h010}, {2'd2, 1'b0, 5'd7, 16'h000},
    {2'd0, 1'b0, 5'd8, 16'h050}, {2'd1, 1'b0, 5'd8, 16'h050},
    {2'd2, 1'b0, 5'd8, 16'h000},
    {2'd0, 1'b0, 5'd9, 16'h020}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_acc(input logic [TAG_W-1:0] t, input logic [ID_W-1:0] id,
                        input bit chk, input bit exp, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_tag = t; acc_id = id;
    @(negedge clk);
    acc_valid = 1'b0;
    if (chk) begin
      check(req, "rsp_valid", 64'(rsp_valid), 64'd1);
      check(req, "rsp_hit", 64'(rsp_hit), 64'(exp));
    end
  endtask

  task automatic do_fill(input logic [TAG_W-1:0] t, input logic [ID_W-1:0] id);
    @(negedge clk);
    fill_valid = 1'b1; fill_tag = t; fill_id = id;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_ret(input logic [ID_W-1:0] id);
    @(negedge clk);
    ret_valid = 1'b1; ret_id = id;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  task automatic do_flush(input logic [ID_W-1:0] id);
    @(negedge clk);
    flush_valid = 1'b1; flush_id = id;
    @(negedge clk);
    flush_valid = 1'b0;
  endtask

  function automatic logic [WAYS*TAG_W-1:0] pack_tags(input logic [TAG_W-1:0] t0,
      input logic [TAG_W-1:0] t1, input logic [TAG_W-1:0] t2, input logic [TAG_W-1:0] t3);
    return {t3, t2, t1, t0};
  endfunction

  function automatic logic [WAYS*2-1:0] pack_ages(input logic [1:0] a0,
      input logic [1:0] a1, input logic [1:0] a2, input logic [1:0] a3);
    return {a3, a2, a1, a0};
  endfunction

  // Retired sequence, optionally with flushed wrong-path traffic mixed in.
  task automatic run_seq(input bit inject);
    logic [TAG_W-1:0] seq_tag [6];
    seq_tag = '{12'h011, 12'h022, 12'h033, 12'h044, 12'h055, 12'h011};
    for (int k = 0; k < 6; k++) begin
      logic [ID_W-1:0] good_id;
      logic [ID_W-1:0] bad_id;
      logic [WAYS*TAG_W-1:0] st;
      logic [WAYS*2-1:0] sa;
      good_id = ID_W'(2 * k + 1);
      bad_id  = ID_W'(2 * k + 2);
      do_acc(seq_tag[k], good_id, 1'b1, 1'b0, "R2");
      if (inject) begin
        st = set_tags; sa = set_ages;
        do_acc(12'h011, bad_id, 1'b0, 1'b0, "R10");
        do_fill(12'h0E0 + TAG_W'(k), bad_id);
        // R3: a parked fill and a wrong-path lookup leave the set as it was
        check("R3", "tags after wrong-path fill", 64'(set_tags), 64'(st));
        check("R3", "ages after wrong-path fill", 64'(set_ages), 64'(sa));
        do_acc(12'h0E0 + TAG_W'(k), bad_id, 1'b1, 1'b1, "R3");
        do_flush(bad_id);
      end
      do_fill(seq_tag[k], good_id);
      do_ret(good_id);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [WAYS*TAG_W-1:0] clean_tags, snap_t;
    logic [WAYS*2-1:0]     clean_ages, snap_a;
    logic [WAYS-1:0]       clean_vld;

    // R1: reset state
    do_reset();
    @(negedge clk);
    check("R1", "set_valid", 64'(set_valid), 64'd0);
    check("R1", "set_ages", 64'(set_ages), 64'(pack_ages(2'd0, 2'd1, 2'd2, 2'd3)));
    check("R1", "fill_ready", 64'(fill_ready), 64'd1);
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);

    // Vector table: R2 lookups, R5 promotions, R6 touch, R11 eviction
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      v = VEC[i];
      case (v[23:22])
        2'd0: do_acc(v[11:0], v[20:16], 1'b1, v[21], "R2");
        2'd1: do_fill(v[11:0], v[20:16]);
        default: do_ret(v[20:16]);
      endcase
    end
    check("R11", "tags after table",
          64'(set_tags), 64'(pack_tags(12'h040, 12'h030, 12'h050, 12'h010)));
    check("R6", "ages after table",
          64'(set_ages), 64'(pack_ages(2'd2, 2'd3, 2'd0, 2'd1)));
    check("R5", "valid after table", 64'(set_valid), 64'hF);

    // R7: retiring an id with no record changes nothing
    snap_t = set_tags; snap_a = set_ages;
    do_ret(5'd20);
    check("R7", "tags", 64'(set_tags), 64'(snap_t));
    check("R7", "ages", 64'(set_ages), 64'(snap_a));

    // R2: a lookup that hits leaves ages unchanged
    do_acc(12'h030, 5'd21, 1'b1, 1'b1, "R2");
    check("R2", "ages after lookup", 64'(set_ages), 64'(snap_a));

    // R4 / R5 / R8: staging capacity, stall, promotion, flush
    do_reset();
    for (int i = 1; i <= 4; i++) do_acc(12'h0A0 + TAG_W'(i), ID_W'(i), 1'b0, 1'b0, "R4");
    for (int i = 1; i <= 4; i++) do_fill(12'h0A0 + TAG_W'(i), ID_W'(i));
    check("R4", "fill_ready when full", 64'(fill_ready), 64'd0);
    do_fill(12'h0A5, 5'd5);
    do_acc(12'h0A5, 5'd6, 1'b1, 1'b0, "R4");
    do_ret(5'd1);
    check("R5", "fill_ready after promote", 64'(fill_ready), 64'd1);
    check("R5", "way3 tag", 64'(set_tags[3*TAG_W +: TAG_W]), 64'h0A1);
    check("R5", "ages after promote",
          64'(set_ages), 64'(pack_ages(2'd1, 2'd2, 2'd3, 2'd0)));
    do_flush(5'd3);
    do_acc(12'h0A2, 5'd2, 1'b1, 1'b1, "R8");
    do_acc(12'h0A3, 5'd9, 1'b1, 1'b0, "R8");
    do_acc(12'h0A4, 5'd9, 1'b1, 1'b0, "R8");
    // R8: flushed record of id 4 is gone, so retiring it changes nothing
    snap_a = set_ages;
    do_ret(5'd4);
    check("R8", "ages after retiring flushed id", 64'(set_ages), 64'(snap_a));

    // R9: duplicate fills take no staging entry
    do_reset();
    do_fill(12'h0B1, 5'd1);
    do_fill(12'h0B1, 5'd2);
    do_fill(12'h0B2, 5'd3);
    do_fill(12'h0B3, 5'd4);
    check("R9", "fill_ready after duplicate", 64'(fill_ready), 64'd1);
    do_fill(12'h0B4, 5'd5);
    check("R9", "fill_ready after 4 distinct", 64'(fill_ready), 64'd0);

    // R10 / R11: clean versus wrong-path replay
    do_reset();
    run_seq(1'b0);
    clean_tags = set_tags; clean_ages = set_ages; clean_vld = set_valid;
    check("R11", "clean tags",
          64'(clean_tags), 64'(pack_tags(12'h044, 12'h033, 12'h011, 12'h055)));
    check("R11", "clean ages",
          64'(clean_ages), 64'(pack_ages(2'd2, 2'd3, 2'd0, 2'd1)));
    do_reset();
    run_seq(1'b1);
    check("R10", "tags match", 64'(set_tags), 64'(clean_tags));
    check("R10", "ages match", 64'(set_ages), 64'(clean_ages));
    check("R10", "valid match", 64'(set_valid), 64'(clean_vld));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule